// File: doc/BRIEF.md
# Integer Execute Unit with Iterative Divide

This block is the integer execute stage of a three-address load/store processor with 32-bit words. For each operation it is given a primary operation code, an extended operation code, two register operands and a 17-bit immediate field. When the primary code selects the register form, the extended code picks the operation and both register operands are used. When the primary code falls in the immediate range, the second operand is the immediate, sign-extended to the full word.

Addition, subtraction, low-word multiplication, bitwise logic, signed comparisons and logical shifts all complete combinationally. `done` and `result` are valid in the same cycle that `start` is presented. Division and remainder use a shared restoring engine that produces one quotient bit per clock. While the engine runs, `busy` stays high and any new `start` is dropped. The surrounding pipeline waits for `done` before it issues the next operation.

Top module: `int_exec_unit`

## Requirements
- R1: With `opcode` = 31 (register form), `xop` 0..15 selects add, sub, mul, div, and, or, xor, eq, ne, lt, le, gt, ge, shl, shr, mod in that order, and `xop` = 23 selects bitwise not of `src_a`. Every operation other than div and mod, when started while `busy` is low, raises `done` and presents `result` in the same cycle as `start`.
- R2: `opcode` 10..25 selects the same sixteen operations in the same order, with the second operand equal to `imm` sign-extended from bit 16 (for example, `imm` = 0x1FFFF acts as -1).
- R3: add, sub and mul return the low 32 bits of the exact two's-complement result and wrap on overflow.
- R4: eq, ne, lt, le, gt and ge compare signed values and return exactly 1 for true and 0 for false.
- R5: shl and shr shift by the low 5 bits of the second operand only. shr fills with zeros.
- R6: If div or mod is started while `busy` is low, `busy` is high in each of the next 33 cycles, and `done` pulses for one cycle in the 33rd cycle after the start cycle, carrying the result.
- R7: div truncates toward zero. mod returns a remainder that takes the sign of the dividend. -2^31 div -1 gives 0x80000000, and the matching mod gives 0.
- R8: A divisor of zero gives quotient 0xFFFFFFFF for div and the unchanged dividend for mod. `div_zero` is high only in that operation's `done` cycle.
- R9: A `start` presented while `busy` is high is ignored. It raises no `done` of its own and does not change the pending division result.
- R10: Undefined codes (primary codes other than 10..25 and 31, and extended codes other than 0..15 and 23) complete in the start cycle with `result` = 0.
- R11: While `rst` is high, `done`, `busy` and `div_zero` are low after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation on the current inputs |
| opcode | input | 5 | Primary operation code |
| xop | input | 12 | Extended operation code, used when `opcode` is 31 |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand (register form) |
| imm | input | 17 | Signed immediate (immediate form) |
| done | output | 1 | Result valid this cycle |
| busy | output | 1 | Divide engine occupied; `start` is ignored |
| result | output | 32 | Operation result, valid while `done` is high |
| div_zero | output | 1 | The completing division had a zero divisor |

## Verification
Two things can meet in one cycle: the divider's completion pulse and a new single-cycle `start`. A `start` can also land on any cycle in the middle of a division. The bench raises `start` on random cycles throughout each division, including the completion cycle. A behavioural model counts down the division independently of the design. On every clock the model expects `done` only from the divider, with the divider's result, and expects nothing from the colliding request.

// File: rtl/int_exec_pkg.sv
`timescale 1ns/1ps
package int_exec_pkg;

    // Operation kinds; the first sixteen follow the extended-code order.
    typedef enum logic [4:0] {
        K_ADD, K_SUB, K_MUL, K_DIV, K_AND, K_OR,  K_XOR, K_EQ,
        K_NE,  K_LT,  K_LE,  K_GT,  K_GE,  K_SHL, K_SHR, K_MOD,
        K_NOT, K_BAD
    } op_kind_e;

    localparam logic [4:0]  OPC_REG    = 5'd31;
    localparam logic [4:0]  OPC_IMM_LO = 5'd10;
    localparam logic [4:0]  OPC_IMM_HI = 5'd25;
    localparam logic [11:0] XOP_LAST   = 12'd15;
    localparam logic [11:0] XOP_NOT    = 12'd23;

    function automatic logic kind_is_div(op_kind_e k);
        return (k == K_DIV) || (k == K_MOD);
    endfunction

    function automatic logic kind_is_cmp(op_kind_e k);
        return (k == K_EQ) || (k == K_NE) || (k == K_LT) ||
               (k == K_LE) || (k == K_GT) || (k == K_GE);
    endfunction

endpackage

// File: rtl/op_decode.sv
`timescale 1ns/1ps
module op_decode
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 17
) (
    input  logic [4:0]        opcode,
    input  logic [11:0]       xop,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output op_kind_e          kind,
    output logic [DATA_W-1:0] operand_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [4:0]        imm_idx;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_idx = opcode - OPC_IMM_LO;

    always_comb begin
        kind      = K_BAD;
        operand_b = src_b;
        if (opcode == OPC_REG) begin
            if (xop <= XOP_LAST)
                kind = op_kind_e'(xop[4:0]);
            else if (xop == XOP_NOT)
                kind = K_NOT;
        end else if (opcode >= OPC_IMM_LO && opcode <= OPC_IMM_HI) begin
            kind      = op_kind_e'(imm_idx);
            operand_b = imm_ext;
        end
    end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    logic            cond;
    logic            lt_s;
    logic            eq_v;

    assign shamt = b[SH_W-1:0];
    assign lt_s  = $signed(a) < $signed(b);
    assign eq_v  = (a == b);

    always_comb begin
        case (kind)
            K_EQ:    cond = eq_v;
            K_NE:    cond = !eq_v;
            K_LT:    cond = lt_s;
            K_LE:    cond = lt_s || eq_v;
            K_GT:    cond = !(lt_s || eq_v);
            K_GE:    cond = !lt_s;
            default: cond = 1'b0;
        endcase
    end

    always_comb begin
        case (kind)
            K_ADD:   y = a + b;
            K_SUB:   y = a - b;
            K_MUL:   y = a * b;
            K_AND:   y = a & b;
            K_OR:    y = a | b;
            K_XOR:   y = a ^ b;
            K_SHL:   y = a << shamt;
            K_SHR:   y = a >> shamt;
            K_NOT:   y = ~a;
            K_EQ, K_NE, K_LT, K_LE, K_GT, K_GE:
                     y = {{(DATA_W-1){1'b0}}, cond};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/div_engine.sv
`timescale 1ns/1ps
module div_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              want_rem,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res,
    output logic              zero_div
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(DATA_W);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rem_q, quo_q, dvs_q, dvd_q;
    logic              negq_q, negr_q, rem_sel_q, zero_q, done_q;
    logic [DATA_W-1:0] res_q;

    // One restoring step
    logic [DATA_W:0]   shifted;
    logic              fits;
    logic [DATA_W:0]   diff;
    logic [DATA_W-1:0] rem_n, quo_n, q_fix, r_fix;

    assign shifted = {rem_q, quo_q[DATA_W-1]};
    assign fits    = shifted >= {1'b0, dvs_q};
    assign diff    = shifted - {1'b0, dvs_q};
    assign rem_n   = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
    assign quo_n   = {quo_q[DATA_W-2:0], fits};
    assign q_fix   = negq_q ? (~quo_n + 1'b1) : quo_n;
    assign r_fix   = negr_q ? (~rem_n + 1'b1) : rem_n;

    logic sa, sb;
    assign sa = dividend[DATA_W-1];
    assign sb = divisor[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_q     <= '0;
            dvd_q     <= '0;
            negq_q    <= 1'b0;
            negr_q    <= 1'b0;
            rem_sel_q <= 1'b0;
            zero_q    <= 1'b0;
            done_q    <= 1'b0;
            res_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy) begin
                cnt       <= STEPS;
                rem_q     <= '0;
                quo_q     <= sa ? (~dividend + 1'b1) : dividend;
                dvs_q     <= sb ? (~divisor + 1'b1) : divisor;
                dvd_q     <= dividend;
                negq_q    <= sa ^ sb;
                negr_q    <= sa;
                rem_sel_q <= want_rem;
                zero_q    <= (divisor == '0);
            end else if (cnt != '0) begin
                cnt   <= cnt - 1'b1;
                rem_q <= rem_n;
                quo_q <= quo_n;
                if (cnt == CNT_W'(1)) begin
                    done_q <= 1'b1;
                    if (zero_q)
                        res_q <= rem_sel_q ? dvd_q : '1;
                    else
                        res_q <= rem_sel_q ? r_fix : q_fix;
                end
            end
        end
    end

    assign busy     = (cnt != '0) || done_q;
    assign done     = done_q;
    assign res      = res_q;
    assign zero_div = done_q && zero_q;

    AST_LOAD_STEPS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (cnt == STEPS)); // R6
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1)); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(1)) |=> (done && busy)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_ZERO_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        zero_div |-> done); // R8
endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        opcode,
    input  logic [11:0]       xop,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              div_zero
);
    op_kind_e          kind;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] eng_res;
    logic              eng_busy, eng_done, eng_zero;
    logic              is_div, accept, eng_start;

    op_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dec (
        .opcode    (opcode),
        .xop       (xop),
        .src_b     (src_b),
        .imm       (imm),
        .kind      (kind),
        .operand_b (opb)
    );

    alu_core #(.DATA_W(DATA_W)) u_alu (
        .kind (kind),
        .a    (src_a),
        .b    (opb),
        .y    (alu_y)
    );

    assign is_div    = kind_is_div(kind);
    assign accept    = start && !eng_busy;
    assign eng_start = accept && is_div;

    div_engine #(.DATA_W(DATA_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .want_rem (kind == K_MOD),
        .dividend (src_a),
        .divisor  (opb),
        .busy     (eng_busy),
        .done     (eng_done),
        .res      (eng_res),
        .zero_div (eng_zero)
    );

    assign busy     = eng_busy;
    assign done     = eng_done || (accept && !is_div);
    assign result   = eng_done ? eng_res : alu_y;
    assign div_zero = eng_zero;

    AST_SINGLE_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !is_div) |-> done); // R1
    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !eng_done) |-> !done); // R9
    AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
        (done && !eng_done && kind_is_cmp(kind)) |-> (result[DATA_W-1:1] == '0)); // R4
    AST_DIV_START_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && is_div) |-> !done); // R6
endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  opcode = 5'd0;
    logic [11:0] xop = 12'd0;
    logic [31:0] src_a = 32'd0;
    logic [31:0] src_b = 32'd0;
    logic [16:0] imm = 17'd0;
    logic        done, busy, div_zero;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    int          cnt = 0;
    logic [31:0] pend_res;
    bit          pend_zero;
    string       pend_tag;

    always #2.5 clk = ~clk;

    int_exec_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .xop(xop),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .done(done), .busy(busy), .result(result), .div_zero(div_zero)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // kind: 0..15 table order, 16 = not, -1 = undefined
    function automatic int kind_of(input logic [4:0] opc, input logic [11:0] xo);
        if (opc == 5'd31) begin
            if (xo <= 12'd15) return int'(xo);
            if (xo == 12'd23) return 16;
            return -1;
        end
        if (opc >= 5'd10 && opc <= 5'd25) return int'(opc) - 10;
        return -1;
    endfunction

    function automatic string tag_of(input int k, input bit immf, input logic [31:0] b);
        if (k == 3 || k == 15) return (b == 0) ? "R8" : "R7";
        if (immf) return "R2";
        case (k)
            0, 1, 2: return "R3";
            7, 8, 9, 10, 11, 12: return "R4";
            13, 14: return "R5";
            -1: return "R10";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [31:0] calc(input int k, input logic [31:0] a, input logic [31:0] b);
        int ia, ib;
        longint la, lb;
        logic [63:0] p;
        ia = int'(a); ib = int'(b);
        la = ia; lb = ib;
        case (k)
            0: return a + b;
            1: return a - b;
            2: begin p = 64'(la * lb); return p[31:0]; end
            3: begin if (b == 0) return 32'hFFFF_FFFF; p = 64'(la / lb); return p[31:0]; end
            15: begin if (b == 0) return a; p = 64'(la % lb); return p[31:0]; end
            4: return a & b;
            5: return a | b;
            6: return a ^ b;
            7: return (ia == ib) ? 32'd1 : 32'd0;
            8: return (ia != ib) ? 32'd1 : 32'd0;
            9: return (ia < ib) ? 32'd1 : 32'd0;
            10: return (ia <= ib) ? 32'd1 : 32'd0;
            11: return (ia > ib) ? 32'd1 : 32'd0;
            12: return (ia >= ib) ? 32'd1 : 32'd0;
            13: return a << b[4:0];
            14: return a >> b[4:0];
            16: return ~a;
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input bit st, input logic [4:0] opc, input logic [11:0] xo,
                        input logic [31:0] a, input logic [31:0] b, input logic [16:0] im);
        int k;
        bit immf, isdiv, e_done, e_busy, e_dz;
        logic [31:0] bop, e_res;
        string t, dtag;
        @(negedge clk);
        start = st; opcode = opc; xop = xo; src_a = a; src_b = b; imm = im;
        #1;
        k = kind_of(opc, xo);
        immf = (opc >= 5'd10 && opc <= 5'd25);
        bop = immf ? {{15{im[16]}}, im} : b;
        isdiv = (k == 3 || k == 15);
        t = tag_of(k, immf, bop);
        e_busy = (cnt > 0);
        e_done = (cnt == 1) || (st && cnt == 0 && !isdiv);
        e_dz = (cnt == 1) && pend_zero;
        e_res = (cnt == 1) ? pend_res : calc(k, a, bop);
        dtag = (cnt == 1) ? pend_tag : ((st && cnt > 0) ? "R9" : (isdiv ? "R6" : "R1"));
        chk(busy === e_busy, "R6", "busy", 32'(busy), 32'(e_busy));
        chk(done === e_done, dtag, "done", 32'(done), 32'(e_done));
        chk(div_zero === e_dz, "R8", "div_zero", 32'(div_zero), 32'(e_dz));
        if (e_done)
            chk(result === e_res, (cnt == 1) ? pend_tag : t, "result", result, e_res);
        if (cnt > 0) cnt--;
        else if (st && isdiv) begin
            cnt = 33;
            pend_res = calc(k, a, bop);
            pend_zero = (bop == 0);
            pend_tag = t;
        end
    endtask

    task automatic xr(input int xo, input logic [31:0] a, input logic [31:0] b);
        step(1'b1, 5'd31, 12'(xo), a, b, 17'd0);
    endtask

    task automatic ii(input int opc, input logic [31:0] a, input logic [16:0] im);
        step(1'b1, 5'(opc), 12'd0, a, 32'hDEAD_BEEF, im);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 5'd0, 12'd0, 32'd0, 32'd0, 17'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R11", "done in reset", 32'(done), 0);
        chk(busy === 1'b0, "R11", "busy in reset", 32'(busy), 0);
        chk(div_zero === 1'b0, "R11", "div_zero in reset", 32'(div_zero), 0);
        rst = 1'b0;

        // R3 wrap
        xr(0, 32'h7FFF_FFFF, 32'd1);
        xr(1, 32'h8000_0000, 32'd1);
        xr(2, 32'h0001_0001, 32'h0001_0001);
        // R1 logic and not
        xr(4, 32'hF0F0_1234, 32'h0FF0_FFFF);
        xr(23, 32'h1234_5678, 32'd0);
        // R4 signed compares
        xr(9, 32'hFFFF_FFFF, 32'd1);
        xr(11, 32'hFFFF_FFFF, 32'd1);
        xr(10, 32'd5, 32'd5);
        xr(8, 32'd5, 32'd5);
        // R5 shifts
        xr(13, 32'd1, 32'd33);
        xr(14, 32'h8000_0000, 32'd31);
        // R2 immediate sign extension
        ii(10, 32'd10, 17'h1FFFF);
        ii(19, 32'hFFFF_FFF0, 17'h10000);
        ii(24, 32'hFFFF_0000, 17'd4);
        // R10 undefined codes
        step(1'b1, 5'd26, 12'd0, 32'd7, 32'd7, 17'd7);
        xr(24, 32'd7, 32'd7);
        // R7 division signs
        xr(3, 32'hFFFF_FFF9, 32'd2); idle(34);
        xr(15, 32'hFFFF_FFF9, 32'd2); idle(34);
        xr(3, 32'h8000_0000, 32'hFFFF_FFFF); idle(34);
        xr(15, 32'h8000_0000, 32'hFFFF_FFFF); idle(34);
        ii(13, 32'd100, 17'h1FFFD); idle(34);
        // R8 zero divisor
        xr(3, 32'hFFFF_FF00, 32'd0); idle(34);
        xr(15, 32'hFFFF_FF00, 32'd0); idle(34);
        // R9 start while busy, including completion cycle
        xr(3, 32'd1000, 32'd7);
        xr(0, 32'd1, 32'd2);
        xr(15, 32'd1, 32'd0);
        idle(30);
        xr(0, 32'd3, 32'd4);
        xr(0, 32'd5, 32'd6);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [31:0] a, b;
            sel = int'($urandom_range(0, 9));
            a = $urandom();
            b = $urandom();
            if (sel == 0) b = 32'd0;
            else if (sel == 1) b = b % 32'd17;
            else if (sel == 2) a = 32'h8000_0000;
            if ($urandom_range(0, 3) == 0)
                step(1'b0, 5'd0, 12'd0, a, b, 17'd0);
            else if ($urandom_range(0, 2) == 0)
                step(1'b1, 5'($urandom_range(8, 27)), 12'd0, a, b, 17'($urandom()));
            else
                step(1'b1, 5'd31, 12'($urandom_range(0, 25)), a, b, 17'd0);
        end
        idle(35);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule